// File: doc/BRIEF.md
# Nibble-Multiplexed Converter Sample Link

This block connects a signal processor to a data-converter front end over four parallel data lines. One 16-bit transmit word and one 16-bit receive word cross the link per sample period. Each word is cut into four nibble slots, and line k carries bits 4k to 4k+3, one bit per slot. A slot is one fast clock in normal mode, or two fast clocks when the half-rate oversampling mode is selected. All launching and capturing happens on the rising clock edge.

On the transmit side the processor's signed 16-bit sample is clamped to the range a 12-bit DAC can represent, and its three lowest bits are cleared. It is loaded only at a word boundary and then sliced onto the lines. On the receive side the lines are collected over four slots. The low 13 bits of the rebuilt word are taken as the ADC code and placed, sign-extended, into a signed 16-bit output with a valid pulse.

A four-state slot sequencer drives the link. Its states are SLOT0, SLOT1, SLOT2 and SLOT3. It moves SLOT0→SLOT1→SLOT2→SLOT3→SLOT0 on every slot step. A slot step happens on every clock in normal mode, and on the second clock of each slot in oversampling mode. Reset forces SLOT0.

Top module: `nibble_conv_link`

## Requirements
- R1: A word lasts four slots, each one clock long (osr2=0) or two clocks long (osr2=1). `word_strobe` is high exactly during slot 0.
- R2: During slot j (0..3), `tx_lines[k]` equals bit 4k+j of the transmit word currently held.
- R3: A transmit sample above 16383 becomes 16383, and a sample below -16384 becomes -16384. Samples inside that range pass through unchanged.
- R4: In the transmit word, bits 2..0 are zero and bits 15 and 14 both equal the sign. Bits 13..3 come from the clamped sample.
- R5: `tx_sample` is taken only at the clock edge that ends slot 3. At any other time its value has no effect. The first word after reset is all zero.
- R6: `rx_lines[k]` is captured as bit 4k+j of the received word in the last clock of slot j. In oversampling mode the first clock of a slot is ignored.
- R7: The ADC code is bits 12..0 of the received word, and bits 15..13 are ignored. `rx_word` holds {code[12], code, 2'b00}.
- R8: `rx_valid` pulses for one clock during the first clock of the following word, together with `word_strobe`. `rx_word` is updated at that same point.
- R9: `nib_clk` stays low when osr2=0. When osr2=1 it is high in the first clock of every slot and low in the second.
- R10: With `rst` high at a clock edge, the link returns to slot 0. After that edge `word_strobe` is 1, `rx_valid` is 0, `rx_word` is 0 and `tx_lines` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast interface clock |
| rst | input | 1 | Synchronous active-high reset |
| osr2 | input | 1 | Half-rate oversampling mode select |
| tx_sample | input | 16 | Signed processor sample to transmit |
| rx_lines | input | 4 | Receive data lines from the converter |
| tx_lines | output | 4 | Transmit data lines to the converter |
| word_strobe | output | 1 | High during slot 0 of each word |
| nib_clk | output | 1 | Half-rate nibble clock, active only in oversampling mode |
| rx_word | output | 16 | Formatted signed receive sample |
| rx_valid | output | 1 | One-clock pulse when `rx_word` is updated |

## Verification
The hardest behaviour to show from the ports is that values are taken in exactly one clock per slot or word. In oversampling mode `rx_lines` must be captured only in the second clock of each slot, and `tx_sample` must be taken only at the final edge of slot 3. A wrong choice of cycle looks correct as long as the inputs stay steady. The stimulus therefore drives the bit-inverted value on the receive lines in every clock that should be ignored. It also holds the inverted transmit sample until the last clock of slot 3, so any capture in the wrong cycle corrupts the checked word.

// File: rtl/nc_pkg.sv
package nc_pkg;
    localparam int unsigned NC_SLOTS = 4;

    typedef enum logic [1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_t;
endpackage

// File: rtl/nc_slot_fsm.sv
module nc_slot_fsm
    import nc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  osr2,
    output slot_t slot,
    output logic  step,
    output logic  last_step,
    output logic  word_strobe,
    output logic  nib_clk
);
    slot_t state_q, state_d;
    logic  half_q, half_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    // next state: advance once per slot
    always_comb begin
        step    = !osr2 || half_q;
        half_d  = osr2 && !half_q;
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SLOT0: state_d = SLOT1;
                SLOT1: state_d = SLOT2;
                SLOT2: state_d = SLOT3;
                SLOT3: state_d = SLOT0;
                default: state_d = SLOT0;
            endcase
        end
    end

    // outputs
    always_comb begin
        slot        = state_q;
        word_strobe = (state_q == SLOT0);
        nib_clk     = osr2 && !half_q;
        last_step   = step && (state_q == SLOT3);
    end
endmodule

// File: rtl/nc_tx_path.sv
module nc_tx_path
    import nc_pkg::*;
#(
    parameter int unsigned LINES    = 4,
    parameter int unsigned DAC_BITS = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  slot_t                        slot,
    input  logic [LINES*NC_SLOTS-1:0]    sample,
    output logic [LINES-1:0]             lines
);
    localparam int unsigned W    = LINES * NC_SLOTS;
    localparam int unsigned DROP = W - 1 - DAC_BITS;
    localparam logic signed [W-1:0] MAXV = {2'b00, {(W-2){1'b1}}};
    localparam logic signed [W-1:0] MINV = {2'b11, {(W-2){1'b0}}};

    logic signed [W-1:0] s_in;
    logic        [W-1:0] sat;
    logic        [W-1:0] fmt;
    logic        [W-1:0] word_q;

    always_comb begin
        s_in = sample;
        if (s_in > MAXV)      sat = MAXV;
        else if (s_in < MINV) sat = MINV;
        else                  sat = s_in;
        fmt = sat;
        fmt[DROP-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= fmt;
    end

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [NC_SLOTS-1:0] nib;
        assign nib      = word_q[k*NC_SLOTS +: NC_SLOTS];
        assign lines[k] = nib[slot];
    end
endmodule

// File: rtl/nc_rx_path.sv
module nc_rx_path
    import nc_pkg::*;
#(
    parameter int unsigned LINES    = 4,
    parameter int unsigned ADC_BITS = 13
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    input  logic                      last_step,
    input  slot_t                     slot,
    input  logic [LINES-1:0]          lines,
    output logic [LINES*NC_SLOTS-1:0] word,
    output logic                      valid
);
    localparam int unsigned W   = LINES * NC_SLOTS;
    localparam int unsigned PAD = W - 1 - ADC_BITS;

    logic [W-1:0]        acc_q;
    logic [W-1:0]        full;
    logic [ADC_BITS-1:0] code;
    logic [W-1:0]        fmt;

    always_comb begin
        full = acc_q;
        for (int k = 0; k < LINES; k++) begin
            full[k*NC_SLOTS + int'(slot)] = lines[k];
        end
        code = full[ADC_BITS-1:0];
        fmt  = '0;
        fmt[W-1]     = code[ADC_BITS-1];
        fmt[W-2:PAD] = code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= last_step;
            if (step)      acc_q <= full;
            if (last_step) word  <= fmt;
        end
    end
endmodule

// File: rtl/nibble_conv_link.sv
module nibble_conv_link
    import nc_pkg::*;
#(
    parameter int unsigned LINES    = 4,
    parameter int unsigned DAC_BITS = 12,
    parameter int unsigned ADC_BITS = 13
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      osr2,
    input  logic [LINES*NC_SLOTS-1:0] tx_sample,
    input  logic [LINES-1:0]          rx_lines,
    output logic [LINES-1:0]          tx_lines,
    output logic                      word_strobe,
    output logic                      nib_clk,
    output logic [LINES*NC_SLOTS-1:0] rx_word,
    output logic                      rx_valid
);
    slot_t slot;
    logic  step;
    logic  last_step;

    nc_slot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .osr2        (osr2),
        .slot        (slot),
        .step        (step),
        .last_step   (last_step),
        .word_strobe (word_strobe),
        .nib_clk     (nib_clk)
    );

    nc_tx_path #(.LINES(LINES), .DAC_BITS(DAC_BITS)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .load   (last_step),
        .slot   (slot),
        .sample (tx_sample),
        .lines  (tx_lines)
    );

    nc_rx_path #(.LINES(LINES), .ADC_BITS(ADC_BITS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .last_step (last_step),
        .slot      (slot),
        .lines     (rx_lines),
        .word      (rx_word),
        .valid     (rx_valid)
    );
endmodule

// File: rtl/nc_link_checks.sv
module nc_link_checks #(
    parameter int unsigned LINES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               osr2,
    input logic [LINES-1:0]   tx_lines,
    input logic               word_strobe,
    input logic               nib_clk,
    input logic [LINES*4-1:0] rx_word,
    input logic               rx_valid
);
    localparam int unsigned W = LINES * 4;

    a_r1_strobe_short: assert property (@(posedge clk) disable iff (rst || osr2)
        word_strobe |=> !word_strobe);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r8_valid_on_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> word_strobe);

    a_r7_rx_shape: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_word[1:0] == 2'b00 && rx_word[W-1] == rx_word[W-2]));

    a_r9_nib_idle: assert property (@(posedge clk) disable iff (rst)
        !osr2 |-> !nib_clk);

    a_r10_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (word_strobe && !rx_valid && tx_lines == '0 && rx_word == '0));
endmodule

bind nibble_conv_link nc_link_checks #(.LINES(LINES)) u_chk (.*);

// File: tb/sim_nibble_conv_link.sv
module sim_nibble_conv_link;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osr2 = 1'b0;
    logic [15:0] tx_sample = '0;
    logic [3:0]  rx_lines = '0;
    logic [3:0]  tx_lines;
    logic        word_strobe;
    logic        nib_clk;
    logic [15:0] rx_word;
    logic        rx_valid;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nibble_conv_link u0 (
        .clk(clk), .rst(rst), .osr2(osr2), .tx_sample(tx_sample),
        .rx_lines(rx_lines), .tx_lines(tx_lines), .word_strobe(word_strobe),
        .nib_clk(nib_clk), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // {tx sample, expected tx word, raw rx word, expected rx_word}
    localparam int NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        {16'h7FFF, 16'h3FF8, 16'h1000, 16'hC000},
        {16'h8000, 16'hC000, 16'h0FFF, 16'h3FFC},
        {16'h3FFF, 16'h3FF8, 16'hE001, 16'h0004},
        {16'h4000, 16'h3FF8, 16'h1FFF, 16'hFFFC},
        {16'hC000, 16'hC000, 16'h0AAA, 16'h2AA8},
        {16'hBFFF, 16'hC000, 16'h5555, 16'hD554},
        {16'h1234, 16'h1230, 16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFF8, 16'hFFFF, 16'hFFFC},
        {16'h0005, 16'h0000, 16'h8003, 16'h000C},
        {16'hABCD, 16'hC000, 16'h0F0F, 16'h3C3C}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst  = 1'b1;
        osr2 = m;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs NV+1 words starting at a negedge in slot 0, cycle 0.
    task automatic run_mode(input bit m);
        int          cyc;
        logic [15:0] prev_tx;
        logic [15:0] pend_rx;
        bit          have_rx;
        cyc     = m ? 2 : 1;
        prev_tx = '0;
        pend_rx = '0;
        have_rx = 1'b0;
        for (int i = 0; i <= NV; i++) begin
            logic [15:0] vtx, etx, vrx, erx, got;
            bit          strobe_ok, nib_ok, valid_low_ok;
            {vtx, etx, vrx, erx} = VEC[i % NV];
            got = '0;
            strobe_ok = 1'b1;
            nib_ok = 1'b1;
            valid_low_ok = 1'b1;
            for (int j = 0; j < 4; j++) begin
                for (int h = 0; h < cyc; h++) begin
                    if (j == 0 && h == 0 && have_rx) begin
                        chk("R8 rx_valid at word start", {15'd0, rx_valid}, 16'd1);
                        chk("R6 R7 rx_word", rx_word, pend_rx);
                    end
                    if (j > 0 && rx_valid) valid_low_ok = 1'b0;
                    if (word_strobe !== (j == 0)) strobe_ok = 1'b0;
                    if (nib_clk !== (m && h == 0)) nib_ok = 1'b0;
                    for (int k = 0; k < 4; k++) got[4*k+j] = tx_lines[k];
                    for (int k = 0; k < 4; k++)
                        rx_lines[k] = (h == cyc - 1) ? vrx[4*k+j] : ~vrx[4*k+j];
                    tx_sample = (j == 3 && h == cyc - 1) ? vtx : ~vtx;
                    @(negedge clk);
                end
            end
            chk("R2 R3 R4 R5 tx line word", got, prev_tx);
            chk("R1 strobe only in slot 0", {15'd0, strobe_ok}, 16'd1);
            chk("R9 nib_clk pattern", {15'd0, nib_ok}, 16'd1);
            chk("R8 rx_valid low mid-word", {15'd0, valid_low_ok}, 16'd1);
            prev_tx = etx;
            pend_rx = erx;
            have_rx = 1'b1;
        end
        chk("R8 rx_valid last word", {15'd0, rx_valid}, 16'd1);
        chk("R7 rx_word last word", rx_word, pend_rx);
    endtask

    initial begin
        do_reset(1'b0);
        // R10 state right after reset
        chk("R10 word_strobe", {15'd0, word_strobe}, 16'd1);
        chk("R10 rx_valid", {15'd0, rx_valid}, 16'd0);
        chk("R10 rx_word", rx_word, 16'h0000);
        chk("R10 tx_lines", {12'd0, tx_lines}, 16'h0000);
        chk("R9 nib_clk normal", {15'd0, nib_clk}, 16'd0);
        run_mode(1'b0);

        do_reset(1'b1);
        chk("R9 nib_clk first cycle osr2", {15'd0, nib_clk}, 16'd1);
        run_mode(1'b1);

        // R10: reset in the middle of a word realigns to slot 0
        do_reset(1'b0);
        tx_sample = 16'h3FFF;
        repeat (4) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R10 pre-reset strobe in slot 2", {15'd0, word_strobe}, 16'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid-word strobe", {15'd0, word_strobe}, 16'd1);
        chk("R10 mid-word rx_valid", {15'd0, rx_valid}, 16'd0);
        chk("R10 mid-word rx_word", rx_word, 16'h0000);
        chk("R10 mid-word tx_lines", {12'd0, tx_lines}, 16'h0000);
        @(negedge clk);
        chk("R1 slot 1 after realign", {15'd0, word_strobe}, 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule